// File: doc/BRIEF.md
# Receive Character Queue with Error Status

This block buffers received characters for one asynchronous serial channel between the receive deserializer and the processor. Each stored entry holds one data character together with three error flags: break, framing and a parity slot. The processor takes characters from the head of the queue with a read strobe. A status word combines the flags of the oldest entry with live channel conditions: queue not empty, queue full, overrun, and two transmitter flags that arrive as plain inputs.

Errors are reported in one of two modes. In per-character mode, the flags of an entry are visible only while that entry is at the head, and they leave the queue when it is read. In accumulate mode, the flags of every character read out are collected into sticky bits. These bits stay set until software issues an error-clear command or a receiver reset. In multidrop operation, the parity slot of each entry carries the received address/data bit instead of a parity result.

Top module: `rx_fifo_stat`

## Requirements
- R1: After the asynchronous reset (rst_n low), the queue is empty and the overrun and sticky flags are clear, so stat[7:4] and stat[1:0] read 0.
- R2: Characters leave in the order they were accepted, up to DEPTH (8) entries. cpu_char shows the head entry's data whenever stat[0] is 1. A cpu_rd while the queue is not empty removes the head at the clock edge.
- R3: stat[0] is 1 exactly when at least one entry is stored. stat[1] is 1 exactly when all DEPTH entries are stored.
- R4: An rx_wr that arrives while the queue is full, with no read in the same cycle, is discarded and sets the overrun flag stat[4]. stat[4] stays 1 until an error-clear or receiver-reset command.
- R5: With blk_mode=0, stat[7], stat[6] and stat[5] show the break, framing and parity-slot flags of the head entry, and read 0 when the queue is empty.
- R6: The parity slot stored with a character depends on par_mode at write time. par_mode=0 (none) stores 0, par_mode=1 (with parity) and par_mode=2 (forced parity) store rx_perr, and par_mode=3 (multidrop) stores rx_adbit.
- R7: With blk_mode=1, every read ORs the head entry's three flags into sticky bits. stat[7:5] shows the sticky bits ORed with the current head's flags, and it stays set after the queue empties.
- R8: cmd_wr with cmd_code=4'h4 (error clear) clears the sticky bits and the overrun flag but leaves the stored characters untouched. It takes priority over a flag being set in the same cycle.
- R9: cmd_wr with cmd_code=4'h2 (receiver reset) empties the queue and clears the sticky and overrun flags. An rx_wr or cpu_rd in the same cycle is ignored.
- R10: stat[3] follows tx_empty and stat[2] follows tx_ready in the same cycle.
- R11: A cpu_rd while the queue is empty has no effect.
- R12: When the queue is full and cpu_rd and rx_wr occur in the same cycle, both take effect: the head is removed, the new character is stored, the queue stays full and no overrun is flagged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_wr | input | 1 | Deserializer delivers a character this cycle |
| rx_char | input | 8 | Received character |
| rx_brk | input | 1 | Character was a break |
| rx_frm | input | 1 | Stop bit missing |
| rx_perr | input | 1 | Parity check failed |
| rx_adbit | input | 1 | Received address/data bit (multidrop) |
| par_mode | input | 2 | 0 none, 1 with parity, 2 forced parity, 3 multidrop |
| blk_mode | input | 1 | 1 selects accumulate error mode |
| cpu_rd | input | 1 | Processor takes the head character |
| cpu_char | output | 8 | Head character data |
| cmd_wr | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code (4'h4 error clear, 4'h2 receiver reset) |
| tx_empty | input | 1 | Transmitter empty flag |
| tx_ready | input | 1 | Transmitter ready flag |
| stat | output | 8 | Status word |

## Verification
The hardest case to reach is the full-queue cycle with a read and a write together, next to a plain write into a full queue. The two differ only in whether overrun is set. The bench fills the queue with directed writes and then applies each case. Sticky accumulation across mode switches and error clears that land on the same edge as a read are covered by a seeded random run. That run flips blk_mode and par_mode over time and issues commands at a low rate, so that flags build up before they are cleared. A model in the bench holds the queue and sticky state and predicts every status field after each edge.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  typedef struct packed {
    logic brk;
    logic frm;
    logic par;
  } rxq_flags_t;

  localparam int FLAG_W = 3;

  typedef enum logic [1:0] {
    PAR_NONE  = 2'd0,
    PAR_WITH  = 2'd1,
    PAR_FORCE = 2'd2,
    PAR_MDROP = 2'd3
  } rxq_par_mode_e;

  localparam logic [3:0] CMD_ERR_CLR = 4'h4;
  localparam logic [3:0] CMD_RX_RST  = 4'h2;

  // value placed in the parity slot of an entry
  function automatic logic rxq_par_slot(input logic [1:0] mode,
                                        input logic perr,
                                        input logic adbit);
    logic r;
    case (rxq_par_mode_e'(mode))
      PAR_WITH, PAR_FORCE: r = perr;
      PAR_MDROP:           r = adbit;
      default:             r = 1'b0;
    endcase
    return r;
  endfunction

  // error field of the status word
  function automatic logic [2:0] rxq_err_field(input rxq_flags_t head,
                                               input logic has_head,
                                               input rxq_flags_t sticky,
                                               input logic blk);
    logic [2:0] h;
    h = has_head ? head : 3'b000;
    return blk ? (h | sticky) : h;
  endfunction

  function automatic logic [7:0] rxq_status(input logic [2:0] err,
                                            input logic ovr,
                                            input logic txe,
                                            input logic txr,
                                            input logic full,
                                            input logic ready);
    return {err, ovr, txe, txr, full, ready};
  endfunction

endpackage

// File: rtl/rxq_fifo.sv
module rxq_fifo #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic             full,
  output logic             empty,
  output logic             pop_ok,
  output logic             reject
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wr_ptr, rd_ptr;
  logic [CNT_W-1:0] count;
  logic             push_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CNT_MAX);
  assign empty   = (count == '0);
  assign pop_ok  = pop && !empty && !flush;
  assign push_ok = push && !flush && (!full || pop_ok);
  assign reject  = push && !flush && !push_ok;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_inc(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CNT_MAX);

  assert_full_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && !pop && !flush) |=> full);

  assert_both_at_full_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (full && push && pop && !flush) |=> (full && !$past(reject)));

  assert_empty_read_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (empty && pop && !push) |=> empty);

endmodule

// File: rtl/rxq_errtrk.sv
module rxq_errtrk
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_clr,
  input  logic       err_clr,
  input  logic       blk,
  input  logic       pop_ok,
  input  rxq_flags_t head,
  input  logic       reject,
  output rxq_flags_t sticky,
  output logic       ovr
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sticky <= '0;
      ovr    <= 1'b0;
    end else if (rx_clr || err_clr) begin
      sticky <= '0;
      ovr    <= 1'b0;
    end else begin
      if (pop_ok && blk) sticky <= sticky | head;
      if (reject)        ovr    <= 1'b1;
    end
  end

  assert_ovr_holds_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !rx_clr && !err_clr) |=> ovr);

  assert_clear_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_clr |=> (sticky == '0 && !ovr));

  assert_no_accum_char_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk && !rx_clr && !err_clr) |=> $stable(sticky));

endmodule

// File: rtl/rx_fifo_stat.sv
module rx_fifo_stat
  import rxq_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_wr,
  input  logic [DATA_W-1:0] rx_char,
  input  logic              rx_brk,
  input  logic              rx_frm,
  input  logic              rx_perr,
  input  logic              rx_adbit,
  input  logic [1:0]        par_mode,
  input  logic              blk_mode,
  input  logic              cpu_rd,
  output logic [DATA_W-1:0] cpu_char,
  input  logic              cmd_wr,
  input  logic [3:0]        cmd_code,
  input  logic              tx_empty,
  input  logic              tx_ready,
  output logic [7:0]        stat
);
  localparam int ENT_W = DATA_W + FLAG_W;

  // named internal events
  logic       err_clr, rx_clr;
  logic       q_full, q_empty, q_pop_ok, q_reject;
  rxq_flags_t in_flags, head_flags, sticky;
  logic       ovr;
  logic [ENT_W-1:0] ent_in, ent_head;
  logic [2:0] err_field;

  assign err_clr = cmd_wr && (cmd_code == CMD_ERR_CLR);
  assign rx_clr  = cmd_wr && (cmd_code == CMD_RX_RST);

  assign in_flags.brk = rx_brk;
  assign in_flags.frm = rx_frm;
  assign in_flags.par = rxq_par_slot(par_mode, rx_perr, rx_adbit);
  assign ent_in       = {in_flags, rx_char};

  rxq_fifo #(.DEPTH(DEPTH), .WIDTH(ENT_W)) fifo_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (rx_clr),
    .push   (rx_wr),
    .pop    (cpu_rd),
    .din    (ent_in),
    .dout   (ent_head),
    .full   (q_full),
    .empty  (q_empty),
    .pop_ok (q_pop_ok),
    .reject (q_reject)
  );

  assign head_flags = rxq_flags_t'(ent_head[ENT_W-1:DATA_W]);
  assign cpu_char   = ent_head[DATA_W-1:0];

  rxq_errtrk err_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .rx_clr  (rx_clr),
    .err_clr (err_clr),
    .blk     (blk_mode),
    .pop_ok  (q_pop_ok),
    .head    (head_flags),
    .reject  (q_reject),
    .sticky  (sticky),
    .ovr     (ovr)
  );

  assign err_field = rxq_err_field(head_flags, !q_empty, sticky, blk_mode);
  assign stat      = rxq_status(err_field, ovr, tx_empty, tx_ready,
                                q_full, !q_empty);

  assert_full_needs_ready_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stat[1] |-> stat[0]);

  assert_empty_no_err_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!blk_mode && !stat[0]) |-> (stat[7:5] == 3'b000));

  assert_flush_empties_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rx_clr |=> (!stat[0] && !stat[4]));

  assert_overrun_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[4]) |-> $past(stat[1] && rx_wr));

endmodule

// File: tb/rx_fifo_stat_tb_top.sv
module rx_fifo_stat_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_wr = 0, rx_brk = 0, rx_frm = 0, rx_perr = 0, rx_adbit = 0;
  logic [7:0] rx_char = '0;
  logic [1:0] par_mode = '0;
  logic blk_mode = 0, cpu_rd = 0, cmd_wr = 0, tx_empty = 0, tx_ready = 0;
  logic [3:0] cmd_code = '0;
  logic [7:0] cpu_char, stat;

  int n_checks = 0;
  int n_fails = 0;
  bit done = 0;

  // bench model
  logic [10:0] m_mem [8];
  int m_head = 0, m_cnt = 0;
  logic [2:0] m_sticky = '0;
  logic m_ovr = 0;

  always #4 clk = ~clk;

  rx_fifo_stat dut_i (
    .clk(clk), .rst_n(rst_n), .rx_wr(rx_wr), .rx_char(rx_char),
    .rx_brk(rx_brk), .rx_frm(rx_frm), .rx_perr(rx_perr), .rx_adbit(rx_adbit),
    .par_mode(par_mode), .blk_mode(blk_mode), .cpu_rd(cpu_rd),
    .cpu_char(cpu_char), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .tx_empty(tx_empty), .tx_ready(tx_ready), .stat(stat)
  );

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("  End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic slot_of(input logic [1:0] m, input logic pe, input logic ad);
    if (m == 2'd3) return ad;
    if (m == 2'd0) return 1'b0;
    return pe;
  endfunction

  function automatic logic [7:0] exp_stat();
    logic [2:0] h;
    h = (m_cnt > 0) ? m_mem[m_head][10:8] : 3'b000;
    if (blk_mode) h = h | m_sticky;
    return {h, m_ovr, tx_empty, tx_ready, (m_cnt == 8), (m_cnt > 0)};
  endfunction

  task automatic model_step();
    int tail;
    bit pop, acc;
    if (cmd_wr && cmd_code == 4'h2) begin
      m_cnt = 0; m_head = 0; m_sticky = '0; m_ovr = 0;
      return;
    end
    tail = (m_head + m_cnt) % 8;
    pop = cpu_rd && (m_cnt > 0);
    acc = rx_wr && ((m_cnt < 8) || pop);
    if (pop && blk_mode) m_sticky = m_sticky | m_mem[m_head][10:8];
    if (rx_wr && !acc) m_ovr = 1;
    if (pop) begin m_head = (m_head + 1) % 8; m_cnt--; end
    if (acc) begin
      m_mem[tail] = {rx_brk, rx_frm, slot_of(par_mode, rx_perr, rx_adbit), rx_char};
      m_cnt++;
    end
    if (cmd_wr && cmd_code == 4'h4) begin m_sticky = '0; m_ovr = 0; end
  endtask

  task automatic check_all();
    logic [7:0] e;
    e = exp_stat();
    chk("R3 ready/full", {6'd0, stat[1:0]}, {6'd0, e[1:0]});
    chk("R4 overrun", {7'd0, stat[4]}, {7'd0, e[4]});
    chk(blk_mode ? "R7 sticky err" : "R5 head err", {5'd0, stat[7:5]}, {5'd0, e[7:5]});
    chk("R10 tx flags", {6'd0, stat[3:2]}, {6'd0, e[3:2]});
    if (m_cnt > 0) chk("R2 head data", cpu_char, m_mem[m_head][7:0]);
  endtask

  task automatic cyc(input bit wr, input logic [7:0] ch, input logic [3:0] fl,
                     input bit rd, input bit cv, input logic [3:0] cc);
    rx_wr = wr; rx_char = ch;
    {rx_brk, rx_frm, rx_perr, rx_adbit} = fl;
    cpu_rd = rd; cmd_wr = cv; cmd_code = cc;
    @(posedge clk);
    model_step();
    @(negedge clk);
    check_all();
  endtask

  task automatic idle();
    cyc(0, 8'h00, 4'h0, 0, 0, 4'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL R2 watchdog actual=timeout expected=completion");
      finish_up();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 reset stat", stat, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", stat, 8'h00);
    tx_empty = 1;
    #1 chk("R10 tx_empty", stat, 8'h08);
    tx_ready = 1;
    #1 chk("R10 tx_ready", stat, 8'h0C);
    tx_empty = 0; tx_ready = 0;

    // R11 read from empty
    cyc(0, 8'h00, 4'h0, 1, 0, 4'h0);
    chk("R11 empty read", stat, 8'h00);
    cyc(1, 8'h5A, 4'h0, 0, 0, 4'h0);
    chk("R11 char after empty read", cpu_char, 8'h5A);
    cyc(0, 8'h00, 4'h0, 1, 0, 4'h0);

    // R6 parity slot per mode: flags {brk,frm,perr,adbit}
    par_mode = 2'd0; cyc(1, 8'h10, 4'b0010, 0, 0, 4'h0);
    par_mode = 2'd1; cyc(1, 8'h11, 4'b0010, 0, 0, 4'h0);
    par_mode = 2'd2; cyc(1, 8'h12, 4'b0010, 0, 0, 4'h0);
    par_mode = 2'd3; cyc(1, 8'h13, 4'b0010, 0, 0, 4'h0);
    cyc(1, 8'h14, 4'b0001, 0, 0, 4'h0);
    chk("R6 none mode slot", {5'd0, stat[7:5]}, 8'h00);
    cyc(0, 8'h00, 4'h0, 1, 0, 4'h0);
    chk("R6 with-parity slot", {5'd0, stat[7:5]}, 8'h01);
    cyc(0, 8'h00, 4'h0, 1, 0, 4'h0);
    chk("R6 forced-parity slot", {5'd0, stat[7:5]}, 8'h01);
    cyc(0, 8'h00, 4'h0, 1, 0, 4'h0);
    chk("R6 multidrop ignores perr", {5'd0, stat[7:5]}, 8'h00);
    cyc(0, 8'h00, 4'h0, 1, 0, 4'h0);
    chk("R6 multidrop adbit", {5'd0, stat[7:5]}, 8'h01);
    cyc(0, 8'h00, 4'h0, 1, 0, 4'h0);
    par_mode = 2'd1;

    // fill to full, then overrun, then simultaneous read/write
    for (int i = 0; i < 8; i++) cyc(1, 8'(8'h20 + i), 4'h0, 0, 0, 4'h0);
    chk("R3 full at 8", {6'd0, stat[1:0]}, 8'h03);
    cyc(1, 8'hEE, 4'h0, 0, 0, 4'h0);
    chk("R4 overrun set", {7'd0, stat[4]}, 8'h01);
    cyc(1, 8'h77, 4'b1000, 1, 0, 4'h0);
    chk("R12 still full", {6'd0, stat[1:0]}, 8'h03);
    chk("R12 head advanced", cpu_char, 8'h21);
    idle();
    chk("R4 overrun holds", {7'd0, stat[4]}, 8'h01);
    cyc(0, 8'h00, 4'h0, 0, 1, 4'h4);
    chk("R8 overrun cleared", {7'd0, stat[4]}, 8'h00);
    chk("R8 contents kept", {6'd0, stat[1:0]}, 8'h03);
    for (int i = 0; i < 8; i++) cyc(0, 8'h00, 4'h0, 1, 0, 4'h0);
    chk("R2 drained", {6'd0, stat[1:0]}, 8'h00);

    // block mode accumulation
    blk_mode = 1;
    cyc(1, 8'h31, 4'b0100, 0, 0, 4'h0);
    cyc(1, 8'h32, 4'b1000, 0, 0, 4'h0);
    cyc(0, 8'h00, 4'h0, 1, 0, 4'h0);
    cyc(0, 8'h00, 4'h0, 1, 0, 4'h0);
    chk("R7 sticky after empty", {5'd0, stat[7:5]}, 8'h06);
    cyc(1, 8'h33, 4'b0010, 0, 0, 4'h0);
    chk("R7 sticky or head", {5'd0, stat[7:5]}, 8'h07);
    cyc(0, 8'h00, 4'h0, 1, 1, 4'h4);
    chk("R8 clear beats accumulate", {5'd0, stat[7:5]}, 8'h00);
    cyc(1, 8'h34, 4'b1100, 0, 0, 4'h0);
    cyc(0, 8'h00, 4'h0, 1, 0, 4'h0);
    cyc(1, 8'h35, 4'h0, 0, 0, 4'h0);
    cyc(1, 8'h36, 4'h0, 1, 1, 4'h2);
    chk("R9 flushed", stat, 8'h00);
    idle();
    chk("R9 write ignored", {6'd0, stat[1:0]}, 8'h00);
    blk_mode = 0;

    // random phase
    for (int n = 0; n < 4000; n++) begin
      bit w, r, c;
      logic [3:0] cc;
      if (n % 500 == 0) blk_mode = $urandom_range(0, 1);
      if (n % 200 == 0) par_mode = 2'($urandom_range(0, 3));
      tx_empty = $urandom_range(0, 1);
      tx_ready = $urandom_range(0, 1);
      w = ($urandom_range(0, 99) < 50);
      r = ($urandom_range(0, 99) < 42);
      c = ($urandom_range(0, 99) < 3);
      case ($urandom_range(0, 2))
        0: cc = 4'h4;
        1: cc = 4'h2;
        default: cc = 4'h7;
      endcase
      cyc(w, 8'($urandom), 4'($urandom), r, c, cc);
    end
    finish_up();
  end
endmodule